// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block merges nineteen level-sensitive interrupt request lines into one interrupt line for the processor. It also tells the processor where the handler for the winning request lives. Software programs the following through a small word-addressed register port:

- the per-channel enable bits, through one write-one-to-set register and one write-one-to-clear register;
- sixteen vector slots, each pairing a channel number with a handler address;
- a fallback handler address.

When a request is taken, the handler address is read from the vector register. The read itself marks the request as taken. Writing zero to that register ends the service.

Priority is by slot: slot 0 is the highest. Any request claimed by an enabled slot outranks one that no slot claims, and all unclaimed requests share a single lowest level. A pending request of higher priority than the one in service raises the interrupt line again, so handlers can nest. Each acknowledge retires the highest-priority level in service, which returns the controller to the level beneath it.

Register offsets, in words:

| Offset | Access | Contents |
|---|---|---|
| 0x00 | read | raw input levels |
| 0x01 | read | masked status |
| 0x02 | read | enable bits; a write sets enable bits |
| 0x03 | write | clears enable bits |
| 0x04 | read/write | vector register |
| 0x05 | read/write | fallback address |
| 0x10+n | read/write | slot n control |
| 0x20+n | read/write | slot n address |

Top module: `irqv_top`

## Requirements
- R1: A read at offset 0x00 returns the 19 request input levels in bits 18:0. A read at offset 0x01 returns those levels ANDed with the enable bits.
- R2: A write at offset 0x02 sets every enable bit whose data bit is 1 and leaves the others unchanged. A read at offset 0x02 returns the enable bits.
- R3: A write at offset 0x03 clears every enable bit whose data bit is 1 and leaves the others unchanged.
- R4: The slot control register at offset 0x10+n holds a channel number in bits 4:0 and a slot-enable bit in bit 5, and reads back as written. An enabled slot whose channel is pending and enabled claims that channel, and the vector register then supplies the slot's address register (offset 0x20+n). A disabled slot claims nothing.
- R5: Among claiming slots the lowest slot number wins. Any claimed request outranks an unclaimed one.
- R6: An enabled pending channel that no enabled slot claims is non-vectored. When the winner is non-vectored, the vector register supplies the fallback address at offset 0x05.
- R7: The interrupt output is high exactly when the winning pending level ranks above the highest-ranked level in service. With nothing in service, this means whenever any enabled channel is pending. A request of equal or lower rank never raises the output.
- R8: A read of offset 0x04 while the interrupt output is high returns the winner's address and marks its level in service. Later reads return the same address until an acknowledge. Writes of a nonzero value to offset 0x04 are ignored.
- R9: A write of zero to offset 0x04 retires the highest-ranked level in service. Reads then return the address of the next level in service, if any.
- R10: After reset, all enable bits, slot registers and the fallback address are zero, and nothing is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| irq_src_i | input | 19 | level request lines, one per channel |
| bus_sel_i | input | 1 | register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | word offset of the register |
| bus_wdata_i | input | 32 | write data |
| bus_rdata_o | output | 32 | read data, valid in the cycle of the access |
| irq_o | output | 1 | interrupt to the processor |

## Verification
Assertions check the following on every cycle:

- the effect of each enable set and clear write on the enable bits;
- the interrupt output is never high without an enabled pending source, and always high when a source is pending with nothing in service;
- a taking read always leaves a level in service;
- each acknowledge retires exactly one level, and a nonzero vector write leaves the service state unchanged.

Only the bench scenarios can show which address a read returns. That covers slot ordering, the fallback for unclaimed and disabled-slot channels, preemption by a higher slot, and the return to the outer level after a nested acknowledge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned REG_AW  = 6;
  localparam int unsigned CH_FW   = 5;   // channel field width in slot control
  localparam int unsigned SLOT_EN = 5;   // slot enable bit position
  localparam int unsigned CTL_W   = CH_FW + 1;

  localparam logic [REG_AW-1:0] OFS_RAW      = 6'h00;
  localparam logic [REG_AW-1:0] OFS_MASKED   = 6'h01;
  localparam logic [REG_AW-1:0] OFS_EN_SET   = 6'h02;
  localparam logic [REG_AW-1:0] OFS_EN_CLR   = 6'h03;
  localparam logic [REG_AW-1:0] OFS_VEC      = 6'h04;
  localparam logic [REG_AW-1:0] OFS_DEFAULT  = 6'h05;
  localparam logic [REG_AW-1:0] OFS_SLOT_CTL = 6'h10;
  localparam logic [REG_AW-1:0] OFS_SLOT_ADR = 6'h20;
endpackage

// File: rtl/irqv_slot_bank.sv
module irqv_slot_bank
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 19,
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned LVL_W     = 5,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             ctl_we_i,
  input  logic                             adr_we_i,
  input  logic [SLOT_W-1:0]                wr_idx_i,
  input  logic [DW-1:0]                    wdata_i,
  input  logic [NUM_SRC-1:0]               masked_i,
  output logic [NUM_SLOTS-1:0][CTL_W-1:0]  slot_ctl_o,
  output logic [NUM_SLOTS-1:0][DW-1:0]     slot_adr_o,
  output logic                             hit_valid_o,
  output logic [LVL_W-1:0]                 hit_lvl_o
);
  logic [31:0]          masked_ext;
  logic [NUM_SLOTS-1:0] hit;

  assign masked_ext = 32'(masked_i);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_ctl_o[s] <= '0;
        slot_adr_o[s] <= '0;
      end else begin
        if (ctl_we_i && wr_idx_i == SLOT_W'(s)) slot_ctl_o[s] <= wdata_i[CTL_W-1:0];
        if (adr_we_i && wr_idx_i == SLOT_W'(s)) slot_adr_o[s] <= wdata_i;
      end
    end
    assign hit[s] = slot_ctl_o[s][SLOT_EN] && masked_ext[slot_ctl_o[s][CH_FW-1:0]];
  end

  // lowest slot index wins
  always_comb begin
    hit_valid_o = 1'b0;
    hit_lvl_o   = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (hit[s]) begin
        hit_valid_o = 1'b1;
        hit_lvl_o   = LVL_W'(s);
      end
    end
  end
endmodule

// File: rtl/irqv_service.sv
module irqv_service #(
  parameter int unsigned NUM_LVL = 17,
  parameter int unsigned LVL_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic [LVL_W-1:0]   take_lvl_i,
  input  logic               ack_i,
  output logic [NUM_LVL-1:0] svc_mask_o,
  output logic               busy_o,
  output logic [LVL_W-1:0]   cur_lvl_o
);
  // cur_lvl_o == NUM_LVL means nothing in service
  always_comb begin
    cur_lvl_o = LVL_W'(NUM_LVL);
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (svc_mask_o[l]) cur_lvl_o = LVL_W'(l);
    end
  end

  assign busy_o = |svc_mask_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_mask_o <= '0;
    end else if (take_i) begin
      svc_mask_o[take_lvl_i] <= 1'b1;
    end else if (ack_i && busy_o) begin
      svc_mask_o[cur_lvl_o] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqv_top.sv
module irqv_top
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 19,
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned NUM_LVL  = NUM_SLOTS + 1,
  localparam int unsigned LVL_W    = $clog2(NUM_SLOTS + 2),
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [REG_AW-1:0]  bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  output logic               irq_o
);
  localparam logic [LVL_W-1:0] LVL_NONVEC = LVL_W'(NUM_SLOTS);

  logic [NUM_SRC-1:0]             en_q, masked;
  logic [DW-1:0]                  def_q;
  logic [NUM_SLOTS-1:0][CTL_W-1:0] slot_ctl;
  logic [NUM_SLOTS-1:0][DW-1:0]    slot_adr;
  logic                           hit_valid, win_valid, busy, take, ack;
  logic [LVL_W-1:0]               hit_lvl, win_lvl, cur_lvl;
  logic [NUM_LVL-1:0]             svc_mask;
  logic [DW-1:0]                  win_adr, cur_adr, vec_rd;
  logic                           wr, rd, in_ctl, in_adr;
  logic [REG_AW-1:0]              ctl_off, adr_off;
  logic [SLOT_W-1:0]              slot_idx;

  assign wr      = bus_sel_i &&  bus_we_i;
  assign rd      = bus_sel_i && !bus_we_i;
  assign ctl_off = bus_addr_i - OFS_SLOT_CTL;
  assign adr_off = bus_addr_i - OFS_SLOT_ADR;
  assign in_ctl  = bus_addr_i >= OFS_SLOT_CTL && ctl_off < REG_AW'(NUM_SLOTS);
  assign in_adr  = bus_addr_i >= OFS_SLOT_ADR && adr_off < REG_AW'(NUM_SLOTS);
  assign slot_idx = in_ctl ? ctl_off[SLOT_W-1:0] : adr_off[SLOT_W-1:0];

  assign masked = irq_src_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      def_q <= '0;
    end else if (wr) begin
      case (bus_addr_i)
        OFS_EN_SET:  en_q  <= en_q |  bus_wdata_i[NUM_SRC-1:0];
        OFS_EN_CLR:  en_q  <= en_q & ~bus_wdata_i[NUM_SRC-1:0];
        OFS_DEFAULT: def_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  irqv_slot_bank #(
    .NUM_SRC  (NUM_SRC),
    .NUM_SLOTS(NUM_SLOTS),
    .LVL_W    (LVL_W)
  ) u_slots (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_we_i   (wr && in_ctl),
    .adr_we_i   (wr && in_adr),
    .wr_idx_i   (slot_idx),
    .wdata_i    (bus_wdata_i),
    .masked_i   (masked),
    .slot_ctl_o (slot_ctl),
    .slot_adr_o (slot_adr),
    .hit_valid_o(hit_valid),
    .hit_lvl_o  (hit_lvl)
  );

  // vectored beats non-vectored
  assign win_valid = hit_valid || (|masked);
  assign win_lvl   = hit_valid ? hit_lvl : LVL_NONVEC;
  assign irq_o     = win_valid && (win_lvl < cur_lvl);

  assign take = rd && bus_addr_i == OFS_VEC && irq_o;
  assign ack  = wr && bus_addr_i == OFS_VEC && bus_wdata_i == '0;

  irqv_service #(
    .NUM_LVL(NUM_LVL),
    .LVL_W  (LVL_W)
  ) u_svc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .take_lvl_i(win_lvl),
    .ack_i     (ack),
    .svc_mask_o(svc_mask),
    .busy_o    (busy),
    .cur_lvl_o (cur_lvl)
  );

  assign win_adr = (win_lvl < LVL_NONVEC) ? slot_adr[win_lvl[SLOT_W-1:0]] : def_q;
  assign cur_adr = (cur_lvl < LVL_NONVEC) ? slot_adr[cur_lvl[SLOT_W-1:0]] : def_q;
  assign vec_rd  = irq_o ? win_adr : (busy ? cur_adr : def_q);

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      if (in_ctl)      bus_rdata_o = DW'(slot_ctl[slot_idx]);
      else if (in_adr) bus_rdata_o = slot_adr[slot_idx];
      else begin
        case (bus_addr_i)
          OFS_RAW:     bus_rdata_o = DW'(irq_src_i);
          OFS_MASKED:  bus_rdata_o = DW'(masked);
          OFS_EN_SET:  bus_rdata_o = DW'(en_q);
          OFS_VEC:     bus_rdata_o = vec_rd;
          OFS_DEFAULT: bus_rdata_o = def_q;
          default:     bus_rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_SRC = 19,
  parameter int unsigned NUM_LVL = 17
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_src_i,
  input logic               bus_sel_i,
  input logic               bus_we_i,
  input logic [REG_AW-1:0]  bus_addr_i,
  input logic [DW-1:0]      bus_wdata_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_LVL-1:0] svc_mask
);
  logic wr_set, wr_clr, vec_ack, vec_nz, vec_rd;
  assign wr_set  = bus_sel_i && bus_we_i && bus_addr_i == OFS_EN_SET;
  assign wr_clr  = bus_sel_i && bus_we_i && bus_addr_i == OFS_EN_CLR;
  assign vec_ack = bus_sel_i && bus_we_i && bus_addr_i == OFS_VEC && bus_wdata_i == '0;
  assign vec_nz  = bus_sel_i && bus_we_i && bus_addr_i == OFS_VEC && bus_wdata_i != '0;
  assign vec_rd  = bus_sel_i && !bus_we_i && bus_addr_i == OFS_VEC;

  assert_enable_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> en_q == ($past(en_q) | $past(bus_wdata_i[NUM_SRC-1:0])));

  assert_enable_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> en_q == ($past(en_q) & ~$past(bus_wdata_i[NUM_SRC-1:0])));

  assert_irq_needs_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(irq_src_i & en_q));

  assert_irq_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_mask == '0 && |(irq_src_i & en_q)) |-> irq_o);

  assert_take_enters_service_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && irq_o) |=> svc_mask != '0);

  assert_nonzero_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_nz |=> $stable(svc_mask));

  assert_ack_retires_one_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_ack && svc_mask != '0) |=> $countones(svc_mask) == $countones($past(svc_mask)) - 1);
endmodule

bind irqv_top irqv_checker #(
  .NUM_SRC(NUM_SRC),
  .NUM_LVL(NUM_LVL)
) u_irqv_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_src_i  (irq_src_i),
  .bus_sel_i  (bus_sel_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .irq_o      (irq_o),
  .en_q       (en_q),
  .svc_mask   (svc_mask)
);

// File: tb/irqv_top_bench.sv
`timescale 1ns/1ps
module irqv_top_bench;
  import irqv_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] src = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;  // 50 MHz

  irqv_top u_irqv_top (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .irq_src_i  (src),
    .bus_sel_i  (sel),
    .bus_we_i   (we),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .irq_o      (irq)
  );

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic exp_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); #1;
    sel = 1'b1; we = 1'b0; addr = a;
    sb_q.push_back('{is_irq: 1'b0, exp: e, tag: tag});
    @(negedge clk); #1;
    sel = 1'b0;
  endtask

  task automatic exp_irq(input logic e, input string tag);
    @(negedge clk); #1;
    sb_q.push_back('{is_irq: 1'b1, exp: 32'(e), tag: tag});
  endtask

  task automatic set_src(input logic [18:0] v);
    @(negedge clk); #1;
    src = v;
  endtask

  // monitor: compares just before each rising edge
  initial begin
    forever begin
      @(negedge clk); #8;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? 32'(irq) : rdata;
        n_vec++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    exp_rd(OFS_RAW, 32'h0, "R10 raw after reset");
    exp_rd(OFS_EN_SET, 32'h0, "R10 enables after reset");
    exp_rd(OFS_VEC, 32'h0, "R10 vector after reset");
    exp_irq(1'b0, "R10 irq after reset");

    set_src(19'h40005);
    exp_rd(OFS_RAW, 32'h40005, "R1 raw levels");
    exp_irq(1'b0, "R7 no enabled source");

    bus_wr(OFS_EN_SET, 32'h5);
    bus_wr(OFS_EN_SET, 32'h10);
    exp_rd(OFS_EN_SET, 32'h15, "R2 set keeps other bits");
    bus_wr(OFS_EN_CLR, 32'h1);
    exp_rd(OFS_EN_SET, 32'h14, "R3 clear only ones");
    exp_rd(OFS_MASKED, 32'h4, "R1 masked status");

    bus_wr(OFS_DEFAULT, 32'hD000_0000);
    exp_irq(1'b1, "R7 idle pending raises irq");
    exp_rd(OFS_VEC, 32'hD000_0000, "R6 non-vectored default");
    exp_irq(1'b0, "R7 in service drops irq");
    bus_wr(OFS_VEC, 32'h1);
    exp_irq(1'b0, "R8 nonzero write ignored");
    exp_rd(OFS_VEC, 32'hD000_0000, "R8 vector stable");
    bus_wr(OFS_VEC, 32'h0);
    exp_irq(1'b1, "R9 ack re-arms");

    bus_wr(OFS_SLOT_CTL + 6'd5, 32'h22);
    bus_wr(OFS_SLOT_ADR + 6'd5, 32'h5000);
    exp_rd(OFS_SLOT_CTL + 6'd5, 32'h22, "R4 slot control readback");
    exp_rd(OFS_VEC, 32'h5000, "R4 slot address supplied");
    exp_irq(1'b0, "R7 slot5 in service");

    bus_wr(OFS_SLOT_CTL + 6'd1, 32'h24);
    bus_wr(OFS_SLOT_ADR + 6'd1, 32'h1000);
    exp_irq(1'b0, "R7 claimed channel not pending");
    set_src(19'h40015);
    exp_irq(1'b1, "R7 higher slot preempts");
    exp_rd(OFS_VEC, 32'h1000, "R5 nested take");
    exp_irq(1'b0, "R7 nested in service");
    set_src(19'h40005);
    bus_wr(OFS_VEC, 32'h0);
    exp_irq(1'b0, "R9 outer level still in service");
    exp_rd(OFS_VEC, 32'h5000, "R9 outer address returned");
    bus_wr(OFS_VEC, 32'h0);
    exp_irq(1'b1, "R9 all retired");

    set_src(19'h40015);
    exp_rd(OFS_VEC, 32'h1000, "R5 lowest slot wins");
    exp_irq(1'b0, "R7 lower rank does not preempt");
    bus_wr(OFS_VEC, 32'h0);

    bus_wr(OFS_SLOT_CTL + 6'd1, 32'h04);
    exp_rd(OFS_VEC, 32'h5000, "R4 disabled slot claims nothing");
    bus_wr(OFS_VEC, 32'h0);
    set_src(19'h40011);
    exp_rd(OFS_VEC, 32'hD000_0000, "R6 disabled-slot channel uses default");
    bus_wr(OFS_VEC, 32'h0);

    bus_wr(OFS_SLOT_CTL + 6'd0, 32'h24);
    bus_wr(OFS_SLOT_ADR + 6'd0, 32'h100);
    bus_wr(OFS_SLOT_CTL + 6'd2, 32'h24);
    bus_wr(OFS_SLOT_ADR + 6'd2, 32'h200);
    bus_wr(OFS_EN_SET, 32'h1);
    exp_rd(OFS_VEC, 32'h100, "R5 lowest slot and vectored over default");
    bus_wr(OFS_VEC, 32'h0);
    exp_irq(1'b1, "R9 pending after ack");

    bus_wr(OFS_EN_CLR, 32'h7FFFF);
    exp_irq(1'b0, "R3 all cleared");
    exp_rd(OFS_MASKED, 32'h0, "R1 masked after clear");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule